// File: doc/BRIEF.md
# Lane Exchange Permute Network

This block moves data sideways across a group of 32 lanes in one issue. Every lane offers one 32-bit word and an 8-bit operand. Each lane then receives a word taken from a source lane. The source lane is picked by one of four addressing modes: a direct lane number, a distance toward lower-numbered sources, a distance toward higher-numbered sources, or an XOR mask on the lane number. Lanes can swap values this way without a round trip through a scratch memory.

Each lane also gets a flag that is set when its source lane exists. In the two distance modes, a lane whose source would fall past either end of the group keeps its own word and clears the flag. An activity mask marks which lanes take part. A lane that is masked off as a destination returns zero and a cleared flag. A lane that is masked off as a source still supplies its word to any lane that reads it. Results are registered and come out one clock after the issue strobe, marked by a one-cycle valid pulse.

Top module: `lane_xchg_net`

## Requirements
- R1: In mode 0 (direct), an active lane k returns the word of lane s, where s is its operand taken modulo 32. Its flag is set.
- R2: In direct mode and in XOR mode, only operand bits [4:0] are used. Operand bits [7:5] have no effect on the result.
- R3: In mode 1 (up), an active lane k with operand n returns the word of lane k−n and sets its flag when n ≤ k. When n > k it returns its own word and clears its flag.
- R4: In mode 2 (down), an active lane k with operand n returns the word of lane k+n and sets its flag when k+n ≤ 31. Otherwise it returns its own word and clears its flag.
- R5: In mode 3 (XOR), an active lane k returns the word of lane k XOR operand[4:0]. Its flag is set.
- R6: A source lane whose mask bit is 0 still supplies its word unchanged to any active lane that reads it.
- R7: A lane whose mask bit is 0 returns zero data and a cleared flag.
- R8: out_valid is high in exactly the cycle after each cycle with in_valid high, and the results for that issue appear in that same cycle. While in_valid is low, out_data and out_inrange hold their values. Back-to-back issues give back-to-back results.
- R9: After reset, out_valid, out_data and out_inrange are all zero.

Lane k's word occupies in_data and out_data bits [32k+31:32k]. Its operand occupies in_opnd bits [8k+7:8k]. Its mask bit is in_active[k], and its flag is out_inrange[k].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| in_valid | input | 1 | Issue strobe for one exchange |
| in_mode | input | 2 | 0 direct, 1 up, 2 down, 3 XOR |
| in_active | input | 32 | Lane activity mask |
| in_data | input | 1024 | Per-lane source words |
| in_opnd | input | 256 | Per-lane operand (index, distance or mask) |
| out_valid | output | 1 | One-cycle pulse marking new results |
| out_data | output | 1024 | Per-lane exchanged words |
| out_inrange | output | 32 | Per-lane source-exists flag |

## Verification
Every result of this block comes out of the single output register, so each issue's words and flags are due exactly one clock after the edge that samples in_valid. The out_valid pulse is due at the same edge. The bench drives at the falling edge. It computes the expected words and flags for the issue from the requirements and queues them. A monitor samples at the following falling edge, after one rising edge has passed, and pops one expected entry for each out_valid it sees. Hold behaviour is checked after several idle cycles, when out_valid must be low and the outputs must still equal the last result.

// File: rtl/lane_xchg_pkg.sv
package lane_xchg_pkg;

  // Addressing modes for the exchange; encoding is visible at the in_mode port.
  typedef enum logic [1:0] {
    XM_DIRECT = 2'd0,
    XM_UP     = 2'd1,
    XM_DOWN   = 2'd2,
    XM_XOR    = 2'd3
  } xchg_mode_e;

endpackage

// File: rtl/lane_rst_sync.sv
module lane_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/lane_src_calc.sv
module lane_src_calc
  import lane_xchg_pkg::*;
#(
  parameter int LANES = 32,
  parameter int OPW   = 8,
  parameter int LANE  = 0,
  localparam int IW   = $clog2(LANES)
) (
  input  logic [1:0]     mode,
  input  logic [OPW-1:0] opnd,
  output logic [IW-1:0]  src,
  output logic           src_ok
);

  // Wide copies so that range checks never wrap.
  localparam logic [OPW:0]  SELF_W = (OPW+1)'(LANE);
  localparam logic [OPW:0]  LAST_W = (OPW+1)'(LANES - 1);
  localparam logic [IW-1:0] SELF_N = IW'(LANE);

  logic [OPW:0]  opnd_w;
  logic [OPW:0]  reach_hi;
  logic [IW-1:0] opnd_lo;
  xchg_mode_e    mode_e;

  always_comb begin
    mode_e   = xchg_mode_e'(mode);
    opnd_w   = {1'b0, opnd};
    opnd_lo  = opnd[IW-1:0];
    reach_hi = SELF_W + opnd_w;
    src      = SELF_N;
    src_ok   = 1'b1;
    unique case (mode_e)
      XM_DIRECT: begin
        src    = opnd_lo;
        src_ok = 1'b1;
      end
      XM_UP: begin
        src_ok = (opnd_w <= SELF_W);
        src    = src_ok ? (SELF_N - opnd_lo) : SELF_N;
      end
      XM_DOWN: begin
        src_ok = (reach_hi <= LAST_W);
        src    = src_ok ? (SELF_N + opnd_lo) : SELF_N;
      end
      XM_XOR: begin
        src    = SELF_N ^ opnd_lo;
        src_ok = 1'b1;
      end
      default: begin
        src    = SELF_N;
        src_ok = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/lane_pick.sv
module lane_pick #(
  parameter int LANES = 32,
  parameter int DW    = 32,
  parameter int LANE  = 0,
  localparam int IW   = $clog2(LANES)
) (
  input  logic [LANES*DW-1:0] words,
  input  logic                dst_active,
  input  logic [IW-1:0]       src,
  input  logic                src_ok,
  output logic [DW-1:0]       pick_data,
  output logic                pick_ok
);

  logic [DW-1:0] fetched;
  logic [DW-1:0] own_word;

  always_comb begin
    // The source mask is deliberately not consulted here.
    fetched  = words[int'(src)*DW +: DW];
    own_word = words[LANE*DW +: DW];
    if (!dst_active) begin
      pick_data = '0;
      pick_ok   = 1'b0;
    end else if (src_ok) begin
      pick_data = fetched;
      pick_ok   = 1'b1;
    end else begin
      pick_data = own_word;
      pick_ok   = 1'b0;
    end
  end

endmodule

// File: rtl/lane_out_reg.sv
module lane_out_reg #(
  parameter int LANES = 32,
  parameter int DW    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [LANES*DW-1:0] nxt_data,
  input  logic [LANES-1:0]    nxt_ok,
  output logic                q_valid,
  output logic [LANES*DW-1:0] q_data,
  output logic [LANES-1:0]    q_ok
);

  logic                valid_d;
  logic [LANES*DW-1:0] data_d;
  logic [LANES-1:0]    ok_d;

  always_comb begin
    valid_d = load;
    data_d  = q_data;
    ok_d    = q_ok;
    if (load) begin
      data_d = nxt_data;
      ok_d   = nxt_ok;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_data  <= '0;
      q_ok    <= '0;
    end else begin
      q_valid <= valid_d;
      q_data  <= data_d;
      q_ok    <= ok_d;
    end
  end

endmodule

// File: rtl/lane_xchg_net.sv
module lane_xchg_net #(
  parameter int LANES = 32,
  parameter int DW    = 32,
  parameter int OPW   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [1:0]          in_mode,
  input  logic [LANES-1:0]    in_active,
  input  logic [LANES*DW-1:0] in_data,
  input  logic [LANES*OPW-1:0] in_opnd,
  output logic                out_valid,
  output logic [LANES*DW-1:0] out_data,
  output logic [LANES-1:0]    out_inrange
);

  localparam int IW = $clog2(LANES);

  logic                rst_sync_n;
  logic [LANES*DW-1:0] res_data;
  logic [LANES-1:0]    res_ok;

  lane_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [IW-1:0] src;
    logic          src_ok;

    lane_src_calc #(
      .LANES (LANES),
      .OPW   (OPW),
      .LANE  (k)
    ) u_src (
      .mode   (in_mode),
      .opnd   (in_opnd[k*OPW +: OPW]),
      .src    (src),
      .src_ok (src_ok)
    );

    lane_pick #(
      .LANES (LANES),
      .DW    (DW),
      .LANE  (k)
    ) u_pick (
      .words      (in_data),
      .dst_active (in_active[k]),
      .src        (src),
      .src_ok     (src_ok),
      .pick_data  (res_data[k*DW +: DW]),
      .pick_ok    (res_ok[k])
    );
  end

  lane_out_reg #(
    .LANES (LANES),
    .DW    (DW)
  ) u_oreg (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (in_valid),
    .nxt_data (res_data),
    .nxt_ok   (res_ok),
    .q_valid  (out_valid),
    .q_data   (out_data),
    .q_ok     (out_inrange)
  );

endmodule

// File: rtl/lane_xchg_net_chk.sv
module lane_xchg_net_chk #(
  parameter int LANES = 32,
  parameter int DW    = 32,
  parameter int OPW   = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic [1:0]           in_mode,
  input logic [LANES-1:0]     in_active,
  input logic [LANES*DW-1:0]  in_data,
  input logic [LANES*OPW-1:0] in_opnd,
  input logic                 out_valid,
  input logic [LANES*DW-1:0]  out_data,
  input logic [LANES-1:0]     out_inrange
);

  a_r8_valid_follow: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_data) && $stable(out_inrange)));

  a_r1_direct_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == 2'd0) |=> (out_inrange == $past(in_active)));

  a_r5_xor_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == 2'd3) |=> (out_inrange == $past(in_active)));

  for (genvar k = 0; k < LANES; k++) begin : g_lane_chk
    a_r7_idle_lane: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_active[k]) |=>
        (out_data[k*DW +: DW] == '0 && !out_inrange[k]));

    a_r3_up_edge: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_mode == 2'd1 && in_active[k] &&
       32'(in_opnd[k*OPW +: OPW]) > k) |=>
        (!out_inrange[k] && out_data[k*DW +: DW] == $past(in_data[k*DW +: DW])));

    a_r4_down_edge: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_mode == 2'd2 && in_active[k] &&
       32'(in_opnd[k*OPW +: OPW]) + k > LANES - 1) |=>
        (!out_inrange[k] && out_data[k*DW +: DW] == $past(in_data[k*DW +: DW])));
  end

endmodule

bind lane_xchg_net lane_xchg_net_chk #(
  .LANES (LANES),
  .DW    (DW),
  .OPW   (OPW)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .in_valid    (in_valid),
  .in_mode     (in_mode),
  .in_active   (in_active),
  .in_data     (in_data),
  .in_opnd     (in_opnd),
  .out_valid   (out_valid),
  .out_data    (out_data),
  .out_inrange (out_inrange)
);

// File: tb/lane_xchg_net_bench.sv
module lane_xchg_net_bench;

  localparam int L   = 32;
  localparam int DW  = 32;
  localparam int OPW = 8;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            in_valid;
  logic [1:0]      in_mode;
  logic [L-1:0]    in_active;
  logic [L*DW-1:0] in_data;
  logic [L*OPW-1:0] in_opnd;
  logic            out_valid;
  logic [L*DW-1:0] out_data;
  logic [L-1:0]    out_inrange;

  always #10 clk = ~clk;

  lane_xchg_net u_lane_xchg_net (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
    .in_active(in_active), .in_data(in_data), .in_opnd(in_opnd),
    .out_valid(out_valid), .out_data(out_data), .out_inrange(out_inrange)
  );

  int n_run  = 0;
  int n_fail = 0;
  bit mon_on = 1'b0;

  logic [L*DW-1:0] exp_d[$];
  logic [L-1:0]    exp_f[$];
  string           exp_t[$];
  logic [L*DW-1:0] last_d = '0;
  logic [L-1:0]    last_f = '0;

  function automatic void model(input logic [1:0] md, input logic [L-1:0] act,
                                input logic [L*DW-1:0] d, input logic [L*OPW-1:0] op,
                                output logic [L*DW-1:0] rd, output logic [L-1:0] rf);
    rd = '0;
    rf = '0;
    for (int k = 0; k < L; k++) begin
      int n;
      int s;
      bit ok;
      n  = int'(op[k*OPW +: OPW]);
      s  = k;
      ok = 1'b1;
      if (act[k]) begin
        case (md)
          2'd0: s = n % L;
          2'd1: if (n > k) ok = 1'b0; else s = k - n;
          2'd2: if (k + n > L - 1) ok = 1'b0; else s = k + n;
          default: s = k ^ (n % L);
        endcase
        rd[k*DW +: DW] = ok ? d[s*DW +: DW] : d[k*DW +: DW];
        rf[k] = ok;
      end
    end
  endfunction

  function automatic logic [L*DW-1:0] pattern(input int seed);
    logic [L*DW-1:0] v;
    for (int k = 0; k < L; k++) v[k*DW +: DW] = {8'(seed), 8'(k), 16'(seed * 977 + k * 131 + 7)};
    return v;
  endfunction

  // Driver: called at a falling edge, issues for one cycle, returns at the next falling edge.
  task automatic send(input logic [1:0] md, input logic [L-1:0] act,
                      input logic [L*DW-1:0] d, input logic [L*OPW-1:0] op, input string tag);
    logic [L*DW-1:0] rd;
    logic [L-1:0]    rf;
    model(md, act, d, op, rd, rf);
    exp_d.push_back(rd);
    exp_f.push_back(rf);
    exp_t.push_back(tag);
    in_mode   = md;
    in_active = act;
    in_data   = d;
    in_opnd   = op;
    in_valid  = 1'b1;
    @(negedge clk);
    in_valid  = 1'b0;
  endtask

  // Monitor: results are due one rising edge after the issue, sampled at the falling edge.
  always @(negedge clk) begin
    if (mon_on && out_valid) begin
      n_run++;
      if (exp_d.size() == 0) begin
        n_fail++;
        $display("FAIL R8 out_valid with nothing issued: actual 1 expected 0");
      end else begin
        logic [L*DW-1:0] ed;
        logic [L-1:0]    ef;
        string           et;
        ed = exp_d.pop_front();
        ef = exp_f.pop_front();
        et = exp_t.pop_front();
        if (out_data !== ed || out_inrange !== ef) begin
          n_fail++;
          for (int k = 0; k < L; k++) begin
            if (out_data[k*DW +: DW] !== ed[k*DW +: DW] || out_inrange[k] !== ef[k]) begin
              $display("FAIL %s lane %0d: actual data %h flag %b expected data %h flag %b",
                       et, k, out_data[k*DW +: DW], out_inrange[k], ed[k*DW +: DW], ef[k]);
              break;
            end
          end
        end
        last_d = ed;
        last_f = ef;
      end
    end
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    logic [L*OPW-1:0] op;
    rst_n     = 1'b0;
    in_valid  = 1'b0;
    in_mode   = 2'd0;
    in_active = '0;
    in_data   = '0;
    in_opnd   = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    n_run++;
    if (out_valid !== 1'b0 || out_data !== '0 || out_inrange !== '0) begin
      n_fail++;
      $display("FAIL R9 reset state: actual valid %b flags %h expected valid 0 flags 0",
               out_valid, out_inrange);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_on = 1'b1;

    // R1: direct, reversed lanes
    for (int k = 0; k < L; k++) op[k*OPW +: OPW] = 8'(L - 1 - k);
    send(2'd0, '1, pattern(1), op, "R1");
    // R2: direct with upper operand bits set, all read lane 7
    for (int k = 0; k < L; k++) op[k*OPW +: OPW] = 8'hE7;
    send(2'd0, '1, pattern(2), op, "R2");
    // R3: up by one, lane 0 out of range
    for (int k = 0; k < L; k++) op[k*OPW +: OPW] = 8'd1;
    send(2'd1, '1, pattern(3), op, "R3");
    // R3: mixed distances, some just past the end, one very large
    for (int k = 0; k < L; k++) op[k*OPW +: OPW] = (k % 3 == 0) ? 8'(k + 1) : 8'(k % 4);
    op[5*OPW +: OPW] = 8'd200;
    send(2'd1, '1, pattern(4), op, "R3");
    // R4: down by three
    for (int k = 0; k < L; k++) op[k*OPW +: OPW] = 8'd3;
    send(2'd2, '1, pattern(5), op, "R4");
    // R4: exact reach of the last lane on even lanes, one past on odd lanes
    for (int k = 0; k < L; k++) op[k*OPW +: OPW] = 8'(L - 1 - k + (k % 2));
    send(2'd2, '1, pattern(6), op, "R4");
    // R5: neighbour swap and half swap
    for (int k = 0; k < L; k++) op[k*OPW +: OPW] = 8'd1;
    send(2'd3, '1, pattern(7), op, "R5");
    for (int k = 0; k < L; k++) op[k*OPW +: OPW] = 8'd16;
    send(2'd3, '1, pattern(8), op, "R5");
    // R2: XOR mask with upper bits set
    for (int k = 0; k < L; k++) op[k*OPW +: OPW] = 8'hA3;
    send(2'd3, '1, pattern(9), op, "R2");
    // R6: every lane reads lane 0, which is masked off as a destination
    for (int k = 0; k < L; k++) op[k*OPW +: OPW] = 8'd0;
    send(2'd0, 32'hFFFF_FFFE, pattern(10), op, "R6");
    // R7: alternate lanes masked off, up by one
    for (int k = 0; k < L; k++) op[k*OPW +: OPW] = 8'd1;
    send(2'd1, 32'hAAAA_AAAA, pattern(11), op, "R7");
    // R8: back-to-back issues
    for (int k = 0; k < L; k++) op[k*OPW +: OPW] = 8'd2;
    send(2'd3, '1, pattern(12), op, "R8");
    for (int k = 0; k < L; k++) op[k*OPW +: OPW] = 8'd1;
    send(2'd2, 32'h0F0F_F0F0, pattern(13), op, "R8");

    // R8: idle cycles with new input values must not disturb the outputs
    in_data   = pattern(99);
    in_mode   = 2'd1;
    in_active = '1;
    repeat (4) @(negedge clk);
    n_run++;
    if (out_valid !== 1'b0 || out_data !== last_d || out_inrange !== last_f ||
        exp_d.size() != 0) begin
      n_fail++;
      $display("FAIL R8 hold while idle: actual valid %b flags %h expected valid 0 flags %h",
               out_valid, out_inrange, last_f);
    end
    summary();
    $finish;
  end

endmodule